// File: doc/BRIEF.md
# Activation Frame Allocation Table

This block keeps the binding between the activation identifiers carried by tokens and the small set of physical frames inside one processing element. There are eight 3-bit activation identifiers but only four frames. A frame is bound when an allocate control token arrives. It is returned to the pool either by a free control token or by a frame-release request from the execution unit. The matching and write paths ask the table, without a clock cycle of delay, whether an identifier is bound and which frame it uses.

Each physical frame runs a two-state machine. The states are FRM_FREE and FRM_BOUND. The transition GRANT moves a frame from FRM_FREE to FRM_BOUND when an accepted allocate selects it. The transition RELEASE moves it back when a free from either source names the identifier bound to it. In every other case a frame holds its state. Each identifier also has a valid bit, so a stale token for a released identifier misses on lookup; no generation counter is used. When an allocate is accepted, the block raises a one-cycle clear strobe together with the chosen frame number. The frame store uses this strobe to wipe the presence bits of the match-operand area, slots 0 to 7. The frame store itself lies outside this block.

Top module: `frame_alloc_table`

## Requirements
- R1: After reset every identifier is unbound, `lk_hit` is 0 for all eight identifiers, `free_count` is 4, and `err_alloc`, `err_free` and `clr_en` are 0.
- R2: An allocate token (`tok_op` = 0) for an unbound identifier, with at least one frame free, binds that identifier to the lowest-numbered free frame. From the next cycle, the lookup of that identifier reports `lk_hit` = 1 and that frame number on `lk_frame`.
- R3: In the same cycle as an accepted allocate, `clr_en` is 1 and `clr_frame` carries the chosen frame number. `clr_en` is 0 in every cycle that has no accepted allocate.
- R4: An allocate that arrives while all four frames stay bound is rejected. `err_alloc` is 1 in the following cycle, and no mapping or count changes.
- R5: An allocate for an identifier that is already bound, and not freed in the same cycle, is rejected. `err_alloc` is 1 in the following cycle, and the existing mapping is unchanged.
- R6: A free token (`tok_op` = 1) for a bound identifier clears its valid bit. From the next cycle its lookup misses, and its frame is counted as free again.
- R7: A release request (`rel_valid` with `rel_act`) for a bound identifier has the same effect as a free token.
- R8: A free, from either source, of an unbound identifier is ignored. `err_free` is 1 in the following cycle, and all mappings and `free_count` are unchanged.
- R9: When an allocate token and a release request arrive in the same cycle, the release is applied first. The allocate can therefore take the frame just released, and it can rebind the identifier just released.
- R10: `free_count` always equals four minus the number of bound identifiers.
- R11: The lookup is combinational: a change on `lk_act` is reflected on `lk_hit` and `lk_frame` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A decoded frame control token is present |
| tok_op | input | 1 | Token operation: 0 allocate, 1 free |
| tok_act | input | 3 | Activation identifier named by the token |
| rel_valid | input | 1 | Frame-release request from the execution unit |
| rel_act | input | 3 | Activation identifier to release |
| lk_act | input | 3 | Lookup identifier |
| lk_hit | output | 1 | Lookup identifier is bound |
| lk_frame | output | 2 | Frame bound to the lookup identifier |
| free_count | output | 3 | Number of unbound frames |
| clr_en | output | 1 | Clear the match presence bits of `clr_frame` |
| clr_frame | output | 2 | Frame selected by the accepted allocate |
| err_alloc | output | 1 | Previous cycle's allocate was rejected |
| err_free | output | 1 | Previous cycle named an unbound identifier in a free |

## Verification
The hardest case to reach is an allocate that would be rejected for a full table or a duplicate identifier, but is saved because a release in the same cycle frees the frame or the identifier it needs. The stimulus first fills all four frames. It then issues an allocate paired with a release of a bound identifier: once for a new identifier, and once for the very identifier being released. After that, a long pseudo-random stream mixes allocate tokens, free tokens and releases, so that freeing and reuse occur in many orders. After each step the bench checks every lookup entry against its own model.

// File: rtl/fat_pkg.sv
package fat_pkg;
    typedef enum logic {
        FRM_FREE  = 1'b0,
        FRM_BOUND = 1'b1
    } frm_state_e;

    localparam logic OP_ALLOC = 1'b0;
    localparam logic OP_FREE  = 1'b1;
endpackage

// File: rtl/frame_pick.sv
module frame_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  avail,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/frame_tally.sv
module frame_tally #(
    parameter int N = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0] is_free,
    output logic [CW-1:0] count
);
    logic [CW-1:0] partial [N+1];

    assign partial[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_sum
        assign partial[g+1] = partial[g] + CW'(is_free[g]);
    end
    assign count = partial[N];
endmodule

// File: rtl/frame_alloc_table.sv
module frame_alloc_table #(
    parameter int NUM_FRAMES = 4,
    parameter int ACT_W      = 3,
    localparam int NUM_ACTS  = 1 << ACT_W,
    localparam int FRM_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W     = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic             tok_op,
    input  logic [ACT_W-1:0] tok_act,
    input  logic             rel_valid,
    input  logic [ACT_W-1:0] rel_act,
    input  logic [ACT_W-1:0] lk_act,
    output logic             lk_hit,
    output logic [FRM_W-1:0] lk_frame,
    output logic [CNT_W-1:0] free_count,
    output logic             clr_en,
    output logic [FRM_W-1:0] clr_frame,
    output logic             err_alloc,
    output logic             err_free
);
    import fat_pkg::*;

    // Per-frame state machines and the identifier-indexed map
    frm_state_e       frm_st   [NUM_FRAMES];
    frm_state_e       frm_st_n [NUM_FRAMES];
    logic [NUM_ACTS-1:0] act_vld, act_vld_n;
    logic [FRM_W-1:0] act_frm   [NUM_ACTS];
    logic [FRM_W-1:0] act_frm_n [NUM_ACTS];
    logic             err_alloc_n, err_free_n;

    // Free handling (applied before allocation)
    logic                  tok_free_req, tok_alloc_req;
    logic [NUM_ACTS-1:0]   freed_acts;
    logic [NUM_FRAMES-1:0] freed_frames;
    logic [NUM_FRAMES-1:0] avail_after;
    logic [NUM_FRAMES-1:0] avail_now;
    logic                  pick_any;
    logic [FRM_W-1:0]      pick_idx;
    logic                  dup_hit, grant;

    assign tok_free_req  = tok_valid && (tok_op == OP_FREE);
    assign tok_alloc_req = tok_valid && (tok_op == OP_ALLOC);

    always_comb begin
        freed_acts   = '0;
        freed_frames = '0;
        err_free_n   = 1'b0;
        if (tok_free_req) begin
            if (act_vld[tok_act]) begin
                freed_acts[tok_act]            = 1'b1;
                freed_frames[act_frm[tok_act]] = 1'b1;
            end else begin
                err_free_n = 1'b1;
            end
        end
        if (rel_valid) begin
            if (act_vld[rel_act]) begin
                freed_acts[rel_act]            = 1'b1;
                freed_frames[act_frm[rel_act]] = 1'b1;
            end else begin
                err_free_n = 1'b1;
            end
        end
    end

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_avail
        assign avail_now[f]   = (frm_st[f] == FRM_FREE);
        assign avail_after[f] = avail_now[f] || freed_frames[f];
    end

    frame_pick #(.N(NUM_FRAMES)) u_pick (
        .avail (avail_after),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    frame_tally #(.N(NUM_FRAMES)) u_tally (
        .is_free (avail_now),
        .count   (free_count)
    );

    assign dup_hit     = act_vld[tok_act] && !freed_acts[tok_act];
    assign grant       = tok_alloc_req && !dup_hit && pick_any;
    assign err_alloc_n = tok_alloc_req && !grant;

    // Next-state logic for each frame state machine
    always_comb begin
        for (int f = 0; f < NUM_FRAMES; f++) begin
            frm_st_n[f] = frm_st[f];
            unique case (frm_st[f])
                FRM_FREE: begin
                    if (grant && (pick_idx == FRM_W'(f)))
                        frm_st_n[f] = FRM_BOUND;            // GRANT
                end
                FRM_BOUND: begin
                    if (freed_frames[f]) begin
                        frm_st_n[f] = FRM_FREE;             // RELEASE
                        if (grant && (pick_idx == FRM_W'(f)))
                            frm_st_n[f] = FRM_BOUND;        // RELEASE then GRANT
                    end
                end
                default: frm_st_n[f] = FRM_FREE;
            endcase
        end
    end

    // Next map contents
    always_comb begin
        act_vld_n = act_vld & ~freed_acts;
        for (int a = 0; a < NUM_ACTS; a++) begin
            act_frm_n[a] = act_frm[a];
        end
        if (grant) begin
            act_vld_n[tok_act] = 1'b1;
            act_frm_n[tok_act] = pick_idx;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FRAMES; f++) frm_st[f] <= FRM_FREE;
            for (int a = 0; a < NUM_ACTS; a++) act_frm[a] <= '0;
            act_vld   <= '0;
            err_alloc <= 1'b0;
            err_free  <= 1'b0;
        end else begin
            for (int f = 0; f < NUM_FRAMES; f++) frm_st[f] <= frm_st_n[f];
            for (int a = 0; a < NUM_ACTS; a++) act_frm[a] <= act_frm_n[a];
            act_vld   <= act_vld_n;
            err_alloc <= err_alloc_n;
            err_free  <= err_free_n;
        end
    end

    // Outputs
    always_comb begin
        lk_hit    = act_vld[lk_act];
        lk_frame  = act_frm[lk_act];
        clr_en    = grant;
        clr_frame = pick_idx;
    end
endmodule

// File: rtl/frame_alloc_table_chk.sv
module frame_alloc_table_chk #(
    parameter int NUM_FRAMES = 4,
    parameter int ACT_W      = 3,
    localparam int NUM_ACTS  = 1 << ACT_W,
    localparam int CNT_W     = $clog2(NUM_FRAMES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tok_valid,
    input logic                tok_op,
    input logic [ACT_W-1:0]    tok_act,
    input logic                rel_valid,
    input logic [CNT_W-1:0]    free_count,
    input logic                clr_en,
    input logic                err_alloc,
    input logic [NUM_ACTS-1:0] act_vld
);
    // R10: bound identifiers and free frames always add up to the frame count
    p_count_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(act_vld) + int'(free_count)) == NUM_FRAMES);

    // R3: a granted allocate with no free in the same cycle consumes one frame
    p_clear_takes_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !rel_valid) |=> (int'(free_count) + 1 == int'($past(free_count))));

    // R4: an allocate with nothing free and nothing released is rejected
    p_full_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_op && free_count == '0 && !rel_valid) |=> err_alloc);

    // R5: an allocate of a bound identifier with no release is rejected
    p_dup_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_op && act_vld[tok_act] && !rel_valid) |=> err_alloc);

    // R2: an accepted allocate never reports an allocation error
    p_grant_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !err_alloc);
endmodule

bind frame_alloc_table frame_alloc_table_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .ACT_W      (ACT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_op     (tok_op),
    .tok_act    (tok_act),
    .rel_valid  (rel_valid),
    .free_count (free_count),
    .clr_en     (clr_en),
    .err_alloc  (err_alloc),
    .act_vld    (act_vld)
);

// File: tb/frame_alloc_table_tb.sv
module frame_alloc_table_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tok_valid, tok_op, rel_valid;
    logic [2:0] tok_act, rel_act, lk_act;
    logic       lk_hit, clr_en, err_alloc, err_free;
    logic [1:0] lk_frame, clr_frame;
    logic [2:0] free_count;

    int tests = 0;
    int fails = 0;

    // Bench model
    bit       m_vld  [8];
    int       m_frm  [8];
    bit       m_busy [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_alloc_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_op(tok_op), .tok_act(tok_act),
        .rel_valid(rel_valid), .rel_act(rel_act),
        .lk_act(lk_act), .lk_hit(lk_hit), .lk_frame(lk_frame),
        .free_count(free_count), .clr_en(clr_en), .clr_frame(clr_frame),
        .err_alloc(err_alloc), .err_free(err_free)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_free();
        int n = 0;
        for (int f = 0; f < 4; f++) if (!m_busy[f]) n++;
        return n;
    endfunction

    task automatic sweep(input string req);
        for (int a = 0; a < 8; a++) begin
            lk_act = 3'(a);
            #1;
            check({req, " R11 hit"}, int'(lk_hit), int'(m_vld[a]));
            if (m_vld[a]) check({req, " R11 frame"}, int'(lk_frame), m_frm[a]);
        end
        check({req, " R10 free_count"}, int'(free_count), model_free());
    endtask

    // One request cycle: drive, check the clear strobe, clock, check errors and the table
    task automatic step(input bit cv, input bit cop, input int ca,
                        input bit rv, input int ra, input string req);
        bit ef = 0, ea = 0, g = 0;
        int pick = -1;
        bit fa [8];
        for (int a = 0; a < 8; a++) fa[a] = 0;
        if (cv && cop) begin
            if (m_vld[ca]) fa[ca] = 1; else ef = 1;
        end
        if (rv) begin
            if (m_vld[ra]) fa[ra] = 1; else ef = 1;
        end
        for (int a = 0; a < 8; a++) if (fa[a]) begin
            m_vld[a] = 0;
            m_busy[m_frm[a]] = 0;
        end
        if (cv && !cop) begin
            for (int f = 3; f >= 0; f--) if (!m_busy[f]) pick = f;
            if (m_vld[ca] || pick < 0) ea = 1;
            else begin
                g = 1;
                m_vld[ca] = 1; m_frm[ca] = pick; m_busy[pick] = 1;
            end
        end
        @(negedge clk);
        tok_valid = cv; tok_op = cop; tok_act = 3'(ca);
        rel_valid = rv; rel_act = 3'(ra);
        #1;
        check({req, " R3 clr_en"}, int'(clr_en), int'(g));
        if (g) check({req, " R2 R3 clr_frame"}, int'(clr_frame), pick);
        @(posedge clk);
        #1;
        tok_valid = 0; rel_valid = 0;
        check({req, " R4 R5 err_alloc"}, int'(err_alloc), int'(ea));
        check({req, " R8 err_free"}, int'(err_free), int'(ef));
        sweep(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int a = 0; a < 8; a++) begin m_vld[a] = 0; m_frm[a] = 0; end
        for (int f = 0; f < 4; f++) m_busy[f] = 0;
        rst_n = 0; tok_valid = 0; tok_op = 0; tok_act = 0;
        rel_valid = 0; rel_act = 0; lk_act = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        check("R1 err_alloc", int'(err_alloc), 0);
        check("R1 err_free", int'(err_free), 0);
        check("R1 clr_en", int'(clr_en), 0);
        sweep("R1 reset");

        // R2: fill frames in lowest-first order
        step(1, 0, 5, 0, 0, "R2 alloc5");
        step(1, 0, 2, 0, 0, "R2 alloc2");
        step(1, 0, 7, 0, 0, "R2 alloc7");
        step(1, 0, 0, 0, 0, "R2 alloc0");
        // R4: full table
        step(1, 0, 3, 0, 0, "R4 full");
        // R6: token free of id 2 (frame 1)
        step(1, 1, 2, 0, 0, "R6 free2");
        // R5: duplicate while a frame is free
        step(1, 0, 5, 0, 0, "R5 dup");
        // R2: reuses frame 1
        step(1, 0, 4, 0, 0, "R2 reuse");
        // R7: release port frees id 7
        step(0, 0, 0, 1, 7, "R7 rel7");
        // R8: free unbound via token and via release
        step(1, 1, 6, 0, 0, "R8 tok unbound");
        step(0, 0, 0, 1, 1, "R8 rel unbound");
        step(1, 0, 1, 0, 0, "R2 fill");
        // R9: full table, allocate new id with a release in the same cycle
        step(1, 0, 6, 1, 5, "R9 swap");
        // R9: allocate the identifier being released
        step(1, 0, 4, 1, 4, "R9 rebind");
        // token free and release of the same identifier together
        step(1, 1, 0, 1, 0, "R6 R7 double");

        // R2-style sweep through pseudo-random mixes
        for (int i = 0; i < 400; i++) begin
            int kind, ca, ra;
            seed = seed * 1103515245 + 12345;
            kind = int'((seed >> 16) % 6);
            ca   = int'((seed >> 8) & 7);
            ra   = int'((seed >> 4) & 7);
            case (kind)
                0, 1: step(1, 0, ca, 0, 0, "R2 rnd alloc");
                2:    step(1, 1, ca, 0, 0, "R6 rnd free");
                3:    step(0, 0, 0, 1, ra, "R7 rnd rel");
                4:    step(1, 0, ca, 1, ra, "R9 rnd mix");
                default: step(0, 0, 0, 0, 0, "R11 idle");
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule